// File: doc/BRIEF.md
# Real-Time Control Serial Receiver

This block takes the serial real-time control stream that an external video decoder sends alongside its picture data and recovers the subcarrier frequency word from it. The encoder uses that word in place of its own programmed subcarrier setting, so the colour subcarrier follows the line-length variations of the incoming video. The word is applied once per line. It is a clean value that a downstream phase accumulator can pick up.

A frame is 67 serial bits long. The frame begins on a low-to-high transition of the frame enable input. Every bit then lasts exactly two clocks and is sampled on the second of them, with bit 0 arriving first. Frame bits 0 to 21 form the subcarrier word, and the other 45 bits are not used. A finished frame waits in a holding register until the next line-start strobe. The strobe copies it to the output and raises a one-clock valid pulse. If the frame enable rises again before a frame is complete, the block discards the partial frame, raises an error flag and starts collecting a new frame at once.

Top module: `rtc_rx`

## Requirements
- R1: While reset is applied and after it is released, `subc_word` is zero and `subc_valid` and `frame_err` are low.
- R2: A frame starts in the cycle where `rtc_frame_en` is high and was low in the cycle before. If that start cycle is cycle S, bit k is sampled from `rtc_ser` only in cycle S+2k+1, which is the second clock of its two-clock period. The value of `rtc_ser` in cycle S+2k is ignored.
- R3: Bit 0 is the first bit received. Frame bits 0 to 21 become `subc_word[0]` to `subc_word[21]` in that order, and frame bits 22 to 66 have no effect on the output.
- R4: `subc_word` changes only when a line-start strobe arrives while a completed frame is waiting. A strobe with no completed frame waiting leaves `subc_word` unchanged and gives no valid pulse.
- R5: `subc_valid` is high for exactly one clock, in the cycle after the strobe that applies a frame. `subc_word` shows the new value in that same cycle.
- R6: A new start while fewer than 67 bits have been collected sets `frame_err` from the next cycle on. The partial frame is never applied, and the new start begins a fresh frame.
- R7: `frame_err` stays high until a frame completes with all 67 bits. It is low from the cycle after that frame's final bit is sampled.
- R8: If several frames complete between two strobes, the strobe applies the most recent one.
- R9: Activity on `rtc_ser` while no frame is in progress does not start a frame.
- R10: The waiting frame can be applied by a strobe in the cycle right after its final sample cycle, that is, in cycle S+134.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rtc_ser | input | 1 | Serial control data, two clocks per bit, least significant bit first |
| rtc_frame_en | input | 1 | Frame enable; a low-to-high transition starts a frame |
| line_start | input | 1 | Line-start strobe that applies a waiting frame |
| subc_word | output | 22 | Applied subcarrier frequency word |
| subc_valid | output | 1 | One-clock pulse when `subc_word` updates |
| frame_err | output | 1 | Set when a frame restarts before it is complete; cleared when a frame completes |

## Verification
The bench drives a deliberately wrong level in the first clock of every bit period. A design that sampled on the first clock, or one clock late, would then show an inverted or shifted word. It strobes in the first cycle after the final sample, so a design that registers completion one cycle late would give no valid pulse there. Frames whose low field is all zeros while the upper bits are all ones expose a design that takes the wrong 22 bits or assembles them in reversed order. Aborted frames with a strobe in the middle, back-to-back frames before a strobe, and random serial toggling while idle catch a design that applies partial data, keeps the older of two frames, or starts a frame on a data edge.

// File: rtl/rtc_rx_pkg.sv
package rtc_rx_pkg;

  // Default geometry of one control frame
  localparam int RTC_FRAME_BITS   = 67;
  localparam int RTC_CLKS_PER_BIT = 2;   // must be 2 or more
  localparam int RTC_FIELD_LSB    = 0;
  localparam int RTC_FIELD_W      = 22;

  typedef enum logic [0:0] {
    RTC_IDLE = 1'b0,
    RTC_RECV = 1'b1
  } rtc_rx_state_e;

  // Per-cycle events produced by the bit timer
  typedef struct packed {
    logic samp;     // this cycle is the sampling clock of a bit
    logic last;     // the sampled bit is the final bit of the frame
    logic restart;  // a start arrived while a frame was in progress
  } rtc_tick_t;

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/rtc_start_det.sv
module rtc_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_en_i,
  output logic start_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d  = frame_en_i;
    start_o = frame_en_i && !prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/rtc_bit_timer.sv
module rtc_bit_timer
  import rtc_rx_pkg::*;
#(
  parameter  int FRAME_BITS   = RTC_FRAME_BITS,
  parameter  int CLKS_PER_BIT = RTC_CLKS_PER_BIT,
  localparam int CW           = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1,
  localparam int BW           = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output rtc_tick_t     tick_o,
  output logic [BW-1:0] bit_idx_o,
  output logic          busy_o
);

  rtc_rx_state_e state_q, state_d;
  logic [CW-1:0] clk_q, clk_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          period_end;

  always_comb begin
    period_end     = (state_q == RTC_RECV) && (clk_q == CW'(CLKS_PER_BIT - 1));
    tick_o.restart = start_i && (state_q == RTC_RECV);
    tick_o.samp    = period_end && !start_i;
    tick_o.last    = tick_o.samp && (bit_q == BW'(FRAME_BITS - 1));

    state_d = state_q;
    clk_d   = clk_q;
    bit_d   = bit_q;

    if (start_i) begin
      // the start cycle is the first clock of bit 0
      state_d = RTC_RECV;
      clk_d   = CW'(1);
      bit_d   = '0;
    end else if (state_q == RTC_RECV) begin
      if (period_end) begin
        clk_d = '0;
        if (tick_o.last) begin
          state_d = RTC_IDLE;
          bit_d   = '0;
        end else begin
          bit_d = bit_q + BW'(1);
        end
      end else begin
        clk_d = clk_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RTC_IDLE;
      clk_q   <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      clk_q   <= clk_d;
      bit_q   <= bit_d;
    end
  end

  assign bit_idx_o = bit_q;
  assign busy_o    = (state_q == RTC_RECV);

endmodule

// File: rtl/rtc_field_shift.sv
module rtc_field_shift
  import rtc_rx_pkg::*;
#(
  parameter  int FRAME_BITS = RTC_FRAME_BITS,
  parameter  int FIELD_LSB  = RTC_FIELD_LSB,
  parameter  int FIELD_W    = RTC_FIELD_W,
  localparam int BW         = $clog2(FRAME_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               samp_i,
  input  logic [BW-1:0]      bit_idx_i,
  input  logic               ser_i,
  output logic [FIELD_W-1:0] field_next_o
);

  logic [FIELD_W-1:0] field_q, field_d;
  logic               lo_ok;
  logic               hi_ok;
  logic               shift_en;
  logic               load_en;
  logic [FIELD_W-1:0] shifted;

  // lower bound of the captured window
  generate
    if (FIELD_LSB == 0) begin : g_lo_open
      assign lo_ok = 1'b1;
    end else begin : g_lo_cmp
      assign lo_ok = (bit_idx_i >= BW'(FIELD_LSB));
    end
  endgenerate

  assign hi_ok = (bit_idx_i < BW'(FIELD_LSB + FIELD_W));

  // least significant bit arrives first: insert at the top, shift down
  generate
    if (FIELD_W == 1) begin : g_w1
      assign shifted = ser_i;
    end else begin : g_wn
      assign shifted = {ser_i, field_q[FIELD_W-1:1]};
    end
  endgenerate

  always_comb begin
    shift_en = samp_i && lo_ok && hi_ok;
    load_en  = start_i || shift_en;
    field_d  = field_q;
    if (start_i) begin
      field_d = '0;
    end else if (shift_en) begin
      field_d = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
    end else if (load_en) begin
      field_q <= field_d;
    end
  end

  assign field_next_o = field_d;

endmodule

// File: rtl/rtc_line_apply.sv
module rtc_line_apply
  import rtc_rx_pkg::*;
#(
  parameter int FIELD_W = RTC_FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               restart_i,
  input  logic               line_start_i,
  output logic [FIELD_W-1:0] word_o,
  output logic               valid_o,
  output logic               err_o
);

  logic               pend_q, pend_d;
  logic [FIELD_W-1:0] hold_q;
  logic [FIELD_W-1:0] word_q;
  logic               valid_q;
  logic               err_q, err_d;
  logic               apply;

  always_comb begin
    apply  = line_start_i && pend_q;
    pend_d = pend_q;
    if (done_i) begin
      pend_d = 1'b1;
    end else if (apply) begin
      pend_d = 1'b0;
    end
    err_d = err_q;
    if (restart_i) begin
      err_d = 1'b1;
    end else if (done_i) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      valid_q <= apply;
      err_q   <= err_d;
    end
  end

  // holding register, loaded when a frame completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (done_i) begin
      hold_q <= field_i;
    end
  end

  // output register, loaded at the line strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (apply) begin
      word_q <= hold_q;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

endmodule

// File: rtl/rtc_rx.sv
module rtc_rx
  import rtc_rx_pkg::*;
#(
  parameter  int FRAME_BITS   = RTC_FRAME_BITS,
  parameter  int CLKS_PER_BIT = RTC_CLKS_PER_BIT,
  parameter  int FIELD_LSB    = RTC_FIELD_LSB,
  parameter  int FIELD_W      = RTC_FIELD_W,
  localparam int BW           = $clog2(FRAME_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rtc_ser,
  input  logic               rtc_frame_en,
  input  logic               line_start,
  output logic [FIELD_W-1:0] subc_word,
  output logic               subc_valid,
  output logic               frame_err
);

  logic               rst_sn;
  logic               start;
  rtc_tick_t          tick;
  logic [BW-1:0]      bit_idx;
  logic               busy;
  logic [FIELD_W-1:0] field_next;
  logic               samp_w;
  logic               last_w;
  logic               restart_w;

  rtc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rtc_start_det u_start (
    .clk        (clk),
    .rst_n      (rst_sn),
    .frame_en_i (rtc_frame_en),
    .start_o    (start)
  );

  rtc_bit_timer #(
    .FRAME_BITS   (FRAME_BITS),
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sn),
    .start_i   (start),
    .tick_o    (tick),
    .bit_idx_o (bit_idx),
    .busy_o    (busy)
  );

  assign samp_w    = tick.samp;
  assign last_w    = tick.last;
  assign restart_w = tick.restart;

  rtc_field_shift #(
    .FRAME_BITS (FRAME_BITS),
    .FIELD_LSB  (FIELD_LSB),
    .FIELD_W    (FIELD_W)
  ) u_shift (
    .clk          (clk),
    .rst_n        (rst_sn),
    .start_i      (start),
    .samp_i       (samp_w),
    .bit_idx_i    (bit_idx),
    .ser_i        (rtc_ser),
    .field_next_o (field_next)
  );

  rtc_line_apply #(
    .FIELD_W (FIELD_W)
  ) u_apply (
    .clk          (clk),
    .rst_n        (rst_sn),
    .done_i       (last_w),
    .field_i      (field_next),
    .restart_i    (restart_w),
    .line_start_i (line_start),
    .word_o       (subc_word),
    .valid_o      (subc_valid),
    .err_o        (frame_err)
  );

endmodule

// File: rtl/rtc_rx_chk.sv
module rtc_rx_chk #(
  parameter  int FRAME_BITS = 67,
  parameter  int FIELD_W    = 22,
  localparam int BW         = $clog2(FRAME_BITS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_start,
  input logic [FIELD_W-1:0] subc_word,
  input logic               subc_valid,
  input logic               frame_err,
  input logic               samp,
  input logic               last,
  input logic               restart,
  input logic               busy,
  input logic [BW-1:0]      bit_idx
);

  // R5: the valid pulse lasts a single clock
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    subc_valid |=> !subc_valid);

  // R5: a valid pulse always follows a line strobe
  a_r5_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    subc_valid |-> $past(line_start));

  // R4: the output word holds unless a valid pulse accompanies it
  a_r4_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !subc_valid |-> $stable(subc_word));

  // R6: the error flag rises only after a restart
  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(restart));

  // R7: the error flag clears only on a completed frame
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> $past(last));

  // R2: sampling clocks are never adjacent
  a_r2_sample_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    samp |=> !samp);

  // R2: the bit index stays inside the frame while receiving
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(bit_idx) < FRAME_BITS));

endmodule

bind rtc_rx rtc_rx_chk #(
  .FRAME_BITS (FRAME_BITS),
  .FIELD_W    (FIELD_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sn),
  .line_start (line_start),
  .subc_word  (subc_word),
  .subc_valid (subc_valid),
  .frame_err  (frame_err),
  .samp       (samp_w),
  .last       (last_w),
  .restart    (restart_w),
  .busy       (busy),
  .bit_idx    (bit_idx)
);

// File: tb/rtc_rx_tb_top.sv
module rtc_rx_tb_top;

  localparam int FB = 67;
  localparam int FW = 22;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ser;
  logic          fen;
  logic          ls;
  logic [FW-1:0] word;
  logic          valid;
  logic          err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench reference state
  logic [FW-1:0] m_word;
  bit            m_pend;
  logic [FW-1:0] m_hold;

  always #5 clk = ~clk;

  rtc_rx dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rtc_ser      (ser),
    .rtc_frame_en (fen),
    .line_start   (ls),
    .subc_word    (word),
    .subc_valid   (valid),
    .frame_err    (err)
  );

  function automatic logic [FW-1:0] exp_field(logic [FB-1:0] f);
    logic [FW-1:0] r;
    for (int i = 0; i < FW; i++) r[i] = f[i];  // frame bit i -> word bit i
    return r;
  endfunction

  function automatic logic [FB-1:0] rnd_frame();
    return FB'({$urandom, $urandom, $urandom});
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      ser = 1'($urandom_range(1, 0));
      @(negedge clk);
    end
  endtask

  // drive n bits of frame f; glitch puts the wrong level in each first clock
  task automatic send(logic [FB-1:0] f, int n, bit glitch, bit restart_chk);
    fen = 1'b1;
    for (int k = 0; k < n; k++) begin
      ser = glitch ? ~f[k] : f[k];
      @(negedge clk);
      if (k == 0 && restart_chk) chk("R6", "frame_err after restart", err, 1);
      ser = f[k];
      @(negedge clk);
    end
    fen = 1'b0;
    ser = 1'($urandom_range(1, 0));
    if (n == FB) begin
      m_pend = 1'b1;
      m_hold = exp_field(f);
      chk("R7", "frame_err after complete frame", err, 0);
    end
  endtask

  task automatic strobe_chk(string req);
    ls = 1'b1;
    @(negedge clk);
    ls = 1'b0;
    if (m_pend) begin
      m_word = m_hold;
      m_pend = 1'b0;
      chk(req, "valid on applying strobe", valid, 1);
    end else begin
      chk(req, "no valid without waiting frame", valid, 0);
    end
    chk(req, "subc_word after strobe", word, m_word);
    @(negedge clk);
    chk("R5", "valid one clock only", valid, 0);
  endtask

  initial begin
    int unsigned seed_v;
    logic [FB-1:0] f;
    seed_v = $urandom(32'd2024);
    rst_n = 1'b0; fen = 1'b0; ser = 1'b0; ls = 1'b0;
    m_word = '0; m_pend = 1'b0; m_hold = '0;
    repeat (3) @(negedge clk);
    chk("R1", "word in reset", word, 0);
    chk("R1", "valid in reset", valid, 0);
    chk("R1", "err in reset", err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "word after reset", word, 0);
    chk("R1", "err after reset", err, 0);

    // R9: serial toggling while idle starts nothing
    idle(40);
    strobe_chk("R9");

    // R10 / R3: plain frame, strobe right after final sample
    f = {45'h0, 22'h2A5C3F} ^ {33'h1_2345_6789, 34'h0};
    send(f, FB, 1'b0, 1'b0);
    strobe_chk("R10");

    // R2: wrong level in first clock of every bit
    idle(2);
    send(rnd_frame(), FB, 1'b1, 1'b0);
    strobe_chk("R2");

    // R3: upper bits all ones, field zero
    idle(2);
    send({{(FB-FW){1'b1}}, {FW{1'b0}}}, FB, 1'b1, 1'b0);
    strobe_chk("R3");
    idle(2);
    send({{(FB-FW){1'b0}}, 22'h000001}, FB, 1'b0, 1'b0);
    strobe_chk("R3");

    // R8: two frames before the strobe
    idle(3);
    send(rnd_frame(), FB, 1'b0, 1'b0);
    idle(3);
    send(rnd_frame(), FB, 1'b1, 1'b0);
    strobe_chk("R8");

    // R6: partial frame, strobe mid-way, then restart
    idle(2);
    send(rnd_frame(), 30, 1'b0, 1'b0);
    strobe_chk("R6");
    chk("R6", "err before restart", err, 0);
    send(rnd_frame(), FB, 1'b1, 1'b1);
    strobe_chk("R6");

    // R4: strobe with nothing waiting
    idle(5);
    strobe_chk("R4");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      op = $urandom_range(3, 0);
      idle($urandom_range(6, 1));
      case (op)
        0: begin
          send(rnd_frame(), FB, 1'($urandom_range(1, 0)), 1'b0);
          idle($urandom_range(4, 0));
          strobe_chk("R3");
        end
        1: begin
          send(rnd_frame(), FB, 1'($urandom_range(1, 0)), 1'b0);
          idle($urandom_range(4, 1));
          send(rnd_frame(), FB, 1'($urandom_range(1, 0)), 1'b0);
          strobe_chk("R8");
        end
        2: begin
          strobe_chk("R4");
        end
        default: begin
          send(rnd_frame(), $urandom_range(60, 1), 1'b0, 1'b0);
          idle(1);
          send(rnd_frame(), FB, 1'($urandom_range(1, 0)), 1'b1);
          strobe_chk("R6");
        end
      endcase
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule